// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block walks a ring of 16-byte receive descriptors that sit in host memory. The controller reads the descriptor at its current ring pointer through a simple request/acknowledge memory port, one 32-bit word per access. If the ownership flag shows the controller owns the descriptor, it hands the 64-bit buffer address and the buffer size to a receive datapath. The datapath then signals that the frame is complete, with its length and tag information. The controller writes a status descriptor back over the same slot, which returns ownership to the host, and then moves to the next slot.

The ring has no programmed length. The slot whose end-of-ring flag is set is the last one, and after it is used the pointer goes back to the ring base. A small register interface loads the base address and provides a kick register. The kick starts the controller after reset, and it also restarts a fetch after the controller has stalled on a descriptor that the host still owns.

The controller is one state machine with these states. `ST_IDLE` waits for the first kick. `ST_FETCH` performs four reads. `ST_CHECK` tests ownership. `ST_EMPTY` stalls until a kick. `ST_BUSY` offers the buffer. `ST_WB_TAG` writes status word 1. `ST_WB_STAT` writes status word 0. `ST_ADVANCE` steps or wraps the pointer.

The transitions are:
- IDLE to FETCH on a kick, which also loads the pointer from the base.
- FETCH to CHECK when the fourth read is acknowledged.
- CHECK to BUSY when the descriptor is owned by the controller, otherwise CHECK to EMPTY.
- EMPTY to FETCH on a kick.
- BUSY to WB_TAG on frame done.
- WB_TAG to WB_STAT on acknowledge.
- WB_STAT to ADVANCE on acknowledge.
- ADVANCE to FETCH always.

Top module: `rxr_ring_ctrl`

## Requirements
- R1: After reset the block makes no memory request, `rx_buf_valid` and `ring_empty` are 0, and it stays inactive until a kick (a write to `cfg_addr` 2).
- R2: A kick from the idle state loads the pointer from the base register (`cfg_addr` 0 writes bits 31:4 of the base, with bits 3:0 forced to 0; `cfg_addr` 1 writes bits 63:32). The block then reads the four descriptor words at pointer +0, +4, +8 and +12, in that order.
- R3: If bit 31 of descriptor word 0 is 1, `rx_buf_valid` rises 9 clock edges after the kick edge when memory acknowledges one cycle after each request. `rx_buf_addr` is {word 3, word 2} and `rx_buf_size` is word 0 bits 13:0, and both hold steady until frame done.
- R4: If bit 31 of word 0 is 0, `ring_empty` goes high, and the block offers no buffer and makes no memory access until a kick. A kick re-fetches the same descriptor.
- R5: On `rx_done`, the block writes status word 1 at pointer +4 before status word 0 at pointer +0. Word 1 has `rx_tag_avail` in bit 16 and `rx_tag` in bits 15:0, with all other bits 0.
- R6: Status word 0 has bit 31 set to 0, bit 30 copied from the fetched end-of-ring flag, bit 21 as the overflow flag, and the stored length in bits 13:0. All other bits are 0.
- R7: If `rx_len` is greater than the buffer size, the stored length is the buffer size and bit 21 is 1. If `rx_len` is less than or equal to the buffer size, the stored length is `rx_len` and bit 21 is 0.
- R8: After writeback the pointer advances by 16. If word 0 bit 30 of that descriptor was 1, the pointer returns to the base instead. The next fetch follows at once.
- R9: A base write made while the ring is running does not move the current pointer. It takes effect only at the next wrap.
- R10: Once `mem_req` is raised, it stays high with the same address, direction and write data until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | 0: base low, 1: base high, 2: kick |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 64 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done (read data valid) |
| mem_rdata | input | 32 | Read data |
| rx_buf_valid | output | 1 | Buffer handed to the datapath |
| rx_buf_addr | output | 64 | Buffer address |
| rx_buf_size | output | 14 | Buffer size in bytes |
| rx_done | input | 1 | Frame complete pulse |
| rx_len | input | 16 | Received frame length |
| rx_tag_avail | input | 1 | Frame carried a tag |
| rx_tag | input | 16 | Tag control value |
| ring_empty | output | 1 | Stalled on a host-owned descriptor |

## Verification
Each memory access takes two edges with the bench memory in its default mode: the acknowledge is registered at the first edge and consumed at the second. A kick therefore brings `rx_buf_valid` high exactly 9 edges later. The bench checks this latency at the falling edges after edge 8 and after edge 9.

All other results have a variable delay, so the bench waits for them by condition and not by a fixed cycle count. These include writebacks, the next fetch and the stall. The memory model keeps an ordered log of accesses, and the checks compare entries of that log, which makes both order and address exact regardless of arrival time. All sampling happens on falling edges. For the hold rule, the memory model is slowed to three extra wait cycles, and a monitor compares the request at each edge with the one before.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int DW         = 32;
    localparam int DESC_BYTES = 16;
    localparam int OWN_BIT    = 31;
    localparam int EOR_BIT    = 30;
    localparam int OVF_BIT    = 21;
    localparam int TAGAV_BIT  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_EMPTY,
        ST_BUSY,
        ST_WB_TAG,
        ST_WB_STAT,
        ST_ADVANCE
    } rxr_state_e;
endpackage

// File: rtl/rxr_cfg.sv
module rxr_cfg #(
    parameter int ADDR_W = 64,
    parameter int CFG_AW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [31:0]          cfg_wdata,
    output logic [ADDR_W-1:0]    base,
    output logic                 kick
);
    localparam int NW = ADDR_W / 32;

    logic [31:0] words [NW];

    for (genvar g = 0; g < NW; g++) begin : g_base
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (cfg_we && cfg_addr == CFG_AW'(g)) begin
                if (g == 0) begin
                    words[g] <= {cfg_wdata[31:4], 4'b0000};
                end else begin
                    words[g] <= cfg_wdata;
                end
            end
        end
        assign base[g*32 +: 32] = words[g];
    end

    assign kick = cfg_we && (cfg_addr == CFG_AW'(NW));
endmodule

// File: rtl/rxr_ptr.sv
module rxr_ptr
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] cur
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= base;
        end else if (step) begin
            cur <= wrap ? base : cur + ADDR_W'(DESC_BYTES);
        end
    end
endmodule

// File: rtl/rxr_status.sv
module rxr_status
    import rxr_pkg::*;
#(
    parameter int SIZE_W  = 14,
    parameter int RXLEN_W = 16,
    parameter int TAG_W   = 16
) (
    input  logic [SIZE_W-1:0]  buf_size,
    input  logic               eor,
    input  logic [RXLEN_W-1:0] rx_len,
    input  logic               tag_avail,
    input  logic [TAG_W-1:0]   tag,
    output logic [DW-1:0]      st_w0,
    output logic [DW-1:0]      st_w1
);
    logic              over;
    logic [SIZE_W-1:0] kept_len;

    always_comb begin
        over     = rx_len > RXLEN_W'(buf_size);
        kept_len = over ? buf_size : rx_len[SIZE_W-1:0];

        st_w0               = '0;
        st_w0[EOR_BIT]      = eor;
        st_w0[OVF_BIT]      = over;
        st_w0[SIZE_W-1:0]   = kept_len;

        st_w1               = '0;
        st_w1[TAGAV_BIT]    = tag_avail;
        st_w1[TAG_W-1:0]    = tag;
    end
endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              rx_done,
    input  logic [DW-1:0]     st_w0,
    input  logic [DW-1:0]     st_w1,
    output logic              ptr_load,
    output logic              ptr_step,
    output logic              ptr_wrap,
    output logic              mem_req,
    output logic              mem_we,
    output logic [3:0]        mem_off,
    output logic [DW-1:0]     mem_wdata,
    output logic              rx_buf_valid,
    output logic [ADDR_W-1:0] rx_buf_addr,
    output logic [SIZE_W-1:0] rx_buf_size,
    output logic              desc_eor,
    output logic              ring_empty
);
    rxr_state_e state, nxt;

    logic [1:0]        wcnt;
    logic              d_own;
    logic              d_eor;
    logic [SIZE_W-1:0] d_size;
    logic [DW-1:0]     d_lo;
    logic [DW-1:0]     d_hi;
    logic [DW-1:0]     s_w0;
    logic [DW-1:0]     s_w1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (kick) nxt = ST_FETCH;
            ST_FETCH:   if (mem_ack && wcnt == 2'd3) nxt = ST_CHECK;
            ST_CHECK:   nxt = d_own ? ST_BUSY : ST_EMPTY;
            ST_EMPTY:   if (kick) nxt = ST_FETCH;
            ST_BUSY:    if (rx_done) nxt = ST_WB_TAG;
            ST_WB_TAG:  if (mem_ack) nxt = ST_WB_STAT;
            ST_WB_STAT: if (mem_ack) nxt = ST_ADVANCE;
            ST_ADVANCE: nxt = ST_FETCH;
            default:    nxt = ST_IDLE;
        endcase
    end

    // descriptor and status capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt   <= '0;
            d_own  <= 1'b0;
            d_eor  <= 1'b0;
            d_size <= '0;
            d_lo   <= '0;
            d_hi   <= '0;
            s_w0   <= '0;
            s_w1   <= '0;
        end else begin
            if (state == ST_FETCH && mem_ack) begin
                wcnt <= wcnt + 2'd1;
                unique case (wcnt)
                    2'd0: begin
                        d_own  <= mem_rdata[OWN_BIT];
                        d_eor  <= mem_rdata[EOR_BIT];
                        d_size <= mem_rdata[SIZE_W-1:0];
                    end
                    2'd2:    d_lo <= mem_rdata;
                    2'd3:    d_hi <= mem_rdata;
                    default: ;
                endcase
            end
            if (state == ST_BUSY && rx_done) begin
                s_w0 <= st_w0;
                s_w1 <= st_w1;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_off      = 4'd0;
        mem_wdata    = '0;
        rx_buf_valid = 1'b0;
        ptr_load     = 1'b0;
        ptr_step     = 1'b0;
        ring_empty   = 1'b0;
        unique case (state)
            ST_IDLE:    ptr_load = kick;
            ST_FETCH: begin
                mem_req = 1'b1;
                mem_off = {wcnt, 2'b00};
            end
            ST_CHECK:   ;
            ST_EMPTY:   ring_empty = 1'b1;
            ST_BUSY:    rx_buf_valid = 1'b1;
            ST_WB_TAG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_off   = 4'd4;
                mem_wdata = s_w1;
            end
            ST_WB_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_off   = 4'd0;
                mem_wdata = s_w0;
            end
            ST_ADVANCE: ptr_step = 1'b1;
            default:    ;
        endcase
    end

    assign ptr_wrap    = d_eor;
    assign desc_eor    = d_eor;
    assign rx_buf_addr = ADDR_W'({d_hi, d_lo});
    assign rx_buf_size = d_size;
endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl
    import rxr_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int SIZE_W  = 14,
    parameter int RXLEN_W = 16,
    parameter int TAG_W   = 16,
    parameter int CFG_AW  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic               mem_ack,
    input  logic [31:0]        mem_rdata,
    output logic               rx_buf_valid,
    output logic [ADDR_W-1:0]  rx_buf_addr,
    output logic [SIZE_W-1:0]  rx_buf_size,
    input  logic               rx_done,
    input  logic [RXLEN_W-1:0] rx_len,
    input  logic               rx_tag_avail,
    input  logic [TAG_W-1:0]   rx_tag,
    output logic               ring_empty
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] cur;
    logic              kick;
    logic              ptr_load, ptr_step, ptr_wrap;
    logic [3:0]        mem_off;
    logic [DW-1:0]     st_w0, st_w1;
    logic              desc_eor;

    rxr_cfg #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .base(base), .kick(kick)
    );

    rxr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .step(ptr_step),
        .wrap(ptr_wrap), .base(base), .cur(cur)
    );

    rxr_status #(.SIZE_W(SIZE_W), .RXLEN_W(RXLEN_W), .TAG_W(TAG_W)) u_status (
        .buf_size(rx_buf_size), .eor(desc_eor), .rx_len(rx_len),
        .tag_avail(rx_tag_avail), .tag(rx_tag), .st_w0(st_w0), .st_w1(st_w1)
    );

    rxr_fsm #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .kick(kick), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .rx_done(rx_done), .st_w0(st_w0), .st_w1(st_w1),
        .ptr_load(ptr_load), .ptr_step(ptr_step), .ptr_wrap(ptr_wrap),
        .mem_req(mem_req), .mem_we(mem_we), .mem_off(mem_off),
        .mem_wdata(mem_wdata), .rx_buf_valid(rx_buf_valid),
        .rx_buf_addr(rx_buf_addr), .rx_buf_size(rx_buf_size),
        .desc_eor(desc_eor), .ring_empty(ring_empty)
    );

    assign mem_addr = cur + ADDR_W'(mem_off);
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
    parameter int ADDR_W = 64,
    parameter int SIZE_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [1:0]        cfg_addr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ack,
    input logic              rx_buf_valid,
    input logic [ADDR_W-1:0] rx_buf_addr,
    input logic [SIZE_W-1:0] rx_buf_size,
    input logic              rx_done,
    input logic              ring_empty
);
    logic kick_seen;
    assign kick_seen = cfg_we && cfg_addr == 2'd2;

    // R10: request held with stable address and direction until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R6: a status word 0 write never leaves the ownership bit set
    p_own_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_addr[3:0] == 4'h0 |-> !mem_wdata[31]);

    // R4: stalled block stays quiet until a kick
    p_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ring_empty |-> !mem_req && !rx_buf_valid);

    p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ring_empty && !kick_seen |=> ring_empty);

    // R3: buffer offer stable until frame done
    p_buf_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_buf_valid && !rx_done |=> rx_buf_valid && $stable(rx_buf_addr) && $stable(rx_buf_size));

    // R5: a frame done is followed by the word 1 write request
    p_wb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_buf_valid && rx_done |=> mem_req && mem_we && mem_addr[3:0] == 4'h4);
endmodule

bind rxr_ring_ctrl rxr_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/tb_rxr_ring_ctrl.sv
module tb_rxr_ring_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rx_buf_valid;
    logic [63:0] rx_buf_addr;
    logic [13:0] rx_buf_size;
    logic        rx_done = 1'b0;
    logic [15:0] rx_len = '0;
    logic        rx_tag_avail = 1'b0;
    logic [15:0] rx_tag = '0;
    logic        ring_empty;

    always #5 clk = ~clk;

    rxr_ring_ctrl dut (.*);

    int nchk = 0, nfail = 0, cyc = 0;
    logic [31:0] mem [256];
    logic [63:0] log_addr [128];
    logic        log_we   [128];
    logic [31:0] log_data [128];
    int          nlog = 0;
    int          mem_delay = 0;
    int          wcount = 0;
    int          hold_viol = 0;
    logic        p_req = 1'b0, p_ack = 1'b0;
    logic [63:0] p_addr = '0;

    localparam logic [63:0] BASE  = 64'h0000_0001_0000_0100;
    localparam logic [63:0] BASE2 = 64'h0000_0001_0000_0200;

    // memory model with access log
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcount  <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wcount < mem_delay) begin
                wcount <= wcount + 1;
            end else begin
                wcount  <= 0;
                mem_ack <= 1'b1;
                log_addr[nlog] <= mem_addr;
                log_we[nlog]   <= mem_we;
                if (mem_we) begin
                    mem[mem_addr[9:2]] <= mem_wdata;
                    log_data[nlog]     <= mem_wdata;
                end else begin
                    mem_rdata      <= mem[mem_addr[9:2]];
                    log_data[nlog] <= mem[mem_addr[9:2]];
                end
                nlog <= nlog + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // request hold monitor (R10)
    always @(posedge clk) begin
        if (rst_n && p_req && !p_ack && (!mem_req || mem_addr != p_addr)) hold_viol++;
        p_req  <= mem_req;
        p_ack  <= mem_ack;
        p_addr <= mem_addr;
    end

    task automatic report();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nchk++; nfail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            report();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_desc(input int w, input logic own, input logic eor,
                            input logic [13:0] size, input logic [31:0] lo, input logic [31:0] hi);
        mem[w]     = {own, eor, 16'h0, size};
        mem[w + 1] = 32'h0;
        mem[w + 2] = lo;
        mem[w + 3] = hi;
    endtask

    task automatic wait_buf();
        for (int i = 0; i < 500 && !rx_buf_valid; i++) @(negedge clk);
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 500 && !ring_empty; i++) @(negedge clk);
    endtask

    task automatic wait_log(input int n);
        for (int i = 0; i < 500 && nlog < n; i++) @(negedge clk);
    endtask

    task automatic send_done(input logic [15:0] len, input logic tav, input logic [15:0] tag);
        @(negedge clk);
        rx_done = 1'b1; rx_len = len; rx_tag_avail = tav; rx_tag = tag;
        @(negedge clk);
        rx_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mem_req", 64'(mem_req), 64'd0);
        chk("R1 rx_buf_valid", 64'(rx_buf_valid), 64'd0);
        chk("R1 ring_empty", 64'(ring_empty), 64'd0);
        repeat (20) @(negedge clk);
        chk("R1 no access before kick", 64'(nlog), 64'd0);
    endtask

    task automatic t_first_fetch();
        cfg_write(2'd0, 32'h0000_0105);
        cfg_write(2'd1, 32'h0000_0001);
        cfg_write(2'd2, 32'h0);
        repeat (8) @(negedge clk);
        chk("R3 not valid after 8 edges", 64'(rx_buf_valid), 64'd0);
        @(negedge clk);
        chk("R3 valid after 9 edges", 64'(rx_buf_valid), 64'd1);
        for (int i = 0; i < 4; i++) begin
            chk("R2 fetch address", log_addr[i], BASE + 64'(4 * i));
            chk("R2 fetch is read", 64'(log_we[i]), 64'd0);
        end
        chk("R3 buffer address", rx_buf_addr, 64'hAAAA_0000_1234_5000);
        chk("R3 buffer size", 64'(rx_buf_size), 64'd200);
    endtask

    task automatic t_writeback();
        send_done(16'd150, 1'b1, 16'h6123);
        wait_log(6);
        chk("R5 word1 address", log_addr[4], BASE + 64'd4);
        chk("R5 word1 write", 64'(log_we[4]), 64'd1);
        chk("R5 word1 data", 64'(log_data[4]), 64'h0001_6123);
        chk("R5 word0 after word1", log_addr[5], BASE);
        chk("R6 status word0", 64'(log_data[5]), 64'h0000_0096);
    endtask

    task automatic t_overflow();
        wait_buf();
        chk("R8 step by 16", log_addr[6], BASE + 64'd16);
        chk("R3 second buffer", rx_buf_addr, 64'h0000_0000_0000_7000);
        send_done(16'd130, 1'b0, 16'h0);
        wait_log(12);
        chk("R7 truncate with overflow", 64'(log_data[11]), 64'h0020_0064);
    endtask

    task automatic t_exact_eor();
        wait_buf();
        chk("R8 third descriptor", log_addr[12], BASE + 64'd32);
        send_done(16'd64, 1'b0, 16'h0);
        wait_log(18);
        chk("R6 R7 eor kept, exact fit", 64'(log_data[17]), 64'h4000_0040);
        chk("R5 word1 no tag", 64'(log_data[16]), 64'h0);
    endtask

    task automatic t_wrap_empty();
        wait_empty();
        chk("R8 wrap to base", log_addr[18], BASE);
        chk("R4 ring_empty", 64'(ring_empty), 64'd1);
        chk("R4 no buffer", 64'(rx_buf_valid), 64'd0);
        repeat (30) @(negedge clk);
        chk("R4 stalled, no access", 64'(nlog), 64'd22);
    endtask

    task automatic t_kick_refetch();
        put_desc(64, 1'b1, 1'b0, 14'd300, 32'h0000_9000, 32'h0);
        cfg_write(2'd2, 32'h0);
        wait_buf();
        chk("R4 refetch same slot", log_addr[22], BASE);
        chk("R4 empty cleared", 64'(ring_empty), 64'd0);
        chk("R3 refetched size", 64'(rx_buf_size), 64'd300);
    endtask

    task automatic t_base_change();
        mem_delay = 3;
        put_desc(128, 1'b1, 1'b1, 14'd40, 32'h0000_5555, 32'h0);
        cfg_write(2'd0, 32'h0000_0200);
        send_done(16'd10, 1'b0, 16'h0);
        wait_empty();
        chk("R9 pointer not moved by base write", log_addr[28], BASE + 64'd16);
        put_desc(68, 1'b1, 1'b1, 14'd50, 32'h0000_6666, 32'h0);
        cfg_write(2'd2, 32'h0);
        wait_buf();
        chk("R9 refetch old slot", log_addr[32], BASE + 64'd16);
        send_done(16'd20, 1'b0, 16'h0);
        wait_buf();
        chk("R9 wrap to new base", log_addr[38], BASE2);
        chk("R3 new ring buffer", rx_buf_addr, 64'h0000_0000_0000_5555);
        chk("R10 request held until ack", 64'(hold_viol), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        put_desc(64, 1'b1, 1'b0, 14'd200, 32'h1234_5000, 32'hAAAA_0000);
        put_desc(68, 1'b1, 1'b0, 14'd100, 32'h0000_7000, 32'h0);
        put_desc(72, 1'b1, 1'b1, 14'd64,  32'h0000_8000, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_fetch();
        t_writeback();
        t_overflow();
        t_exact_eor();
        t_wrap_empty();
        t_kick_refetch();
        t_base_change();
        report();
        $finish;
    end
endmodule